// File: doc/BRIEF.md
# Single-Precision Special-Operand Finalization Stage

This stage sits between the operand read and the destination write of a single-precision floating-point unit. It looks at up to two 32-bit operands and sorts each into one of six classes: zero, normal, infinity, subnormal, quiet NaN or signaling NaN. Any subnormal operand is replaced by a zero of the same sign before it goes to the arithmetic core. The core's raw result comes back in the same cycle. The stage then settles the value that is written back, whether the destination register is written at all, and whether an invalid-operation exception is raised.

This FPU marks a NaN as signaling when the top fraction bit is one, and as quiet when that bit is zero. This is the opposite of the more common convention. Every quiet NaN the stage produces is the fixed word 0x7FBFFFFF. A copy operation skips all of this handling and passes its operand through unchanged. Results leave a register stage one cycle after the accepted input, together with a valid flag.

Top module: `fp_special_stage`

## Requirements
- R1: A word is a NaN when bits 30:23 are all ones and bits 22:0 are not all zero. Bit 31 plays no part in this test. The NaN is signaling when bit 22 is 1 and quiet when bit 22 is 0.
- R2: Take a non-copy operation with `inv_en` low and a signaling NaN in any active operand. The stage outputs `0x7FBFFFFF`, drives `out_wr_en` high and leaves `out_inv_exc` low.
- R3: Take a non-copy operation with `inv_en` high and a signaling NaN in any active operand. The stage raises `out_inv_exc` and holds `out_wr_en` low. A write is suppressed in no other case.
- R4: Take a non-copy operation where some active operand is a quiet NaN and no active operand is a signaling NaN. The stage outputs `0x7FBFFFFF` with `out_wr_en` high and no exception, for either value of `inv_en`.
- R5: For a non-copy operation, an operand with zero exponent and nonzero fraction reaches `core_opa`/`core_opb` as a zero that keeps its sign bit. Any other operand reaches the core unchanged. Both outputs are combinational.
- R6: For a non-copy operation with no NaN operand, the output is `core_res`. If `core_res` has a zero exponent and a nonzero fraction, it is first replaced by a zero that keeps its sign bit.
- R7: When `is_copy` is high, `out_result` equals `op_a` bit for bit, `out_wr_en` is high and `out_inv_exc` is low. Both operands also reach the core unflushed.
- R8: When `two_ops` is low, the content of `op_b` has no effect on the result, the write enable or the exception.
- R9: The outputs for an input accepted with `in_valid` high appear one clock later with `out_valid` high. On a cycle after `in_valid` was low, `out_valid`, `out_wr_en` and `out_inv_exc` are all low.
- R10: While `rst_n` is low at a clock edge, `out_valid`, `out_wr_en` and `out_inv_exc` are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation presented this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| two_ops | input | 1 | op_b takes part in the operation |
| is_copy | input | 1 | Operation is a plain copy of op_a |
| inv_en | input | 1 | Invalid-operation exception enable |
| core_opa | output | 32 | First operand as sent to the arithmetic core |
| core_opb | output | 32 | Second operand as sent to the arithmetic core |
| core_res | input | 32 | Raw result returned by the core |
| out_valid | output | 1 | Registered outputs are meaningful |
| out_result | output | 32 | Final value for the destination |
| out_wr_en | output | 1 | Destination register is written |
| out_inv_exc | output | 1 | Invalid-operation exception pulse |

## Verification
The bench builds each operand and the core result from six classes: zero, normal, infinity, subnormal, quiet NaN and signaling NaN. Within each class it varies the sign, exponent and fraction, and it sweeps every combination of the two operand classes, the core-result class, `two_ops`, `is_copy` and `inv_en`. The pairings of signaling NaN with quiet NaN separate signaling-NaN priority from the plain quiet-NaN path. A signaling NaN placed only in `op_b` with `two_ops` low shows that the inactive operand is truly ignored. Subnormal values with both signs, in both the operands and the core result, show that the flush keeps the sign. The copy cases with NaN and subnormal inputs prove the bypass.

// File: rtl/fpss_pkg.sv
// Package fpss_pkg: shared operand-class type for the special-operand stage.
// Assumes nothing beyond IEEE-754-style field layout (sign, exponent, fraction).
package fpss_pkg;
    typedef enum logic [2:0] {
        FC_ZERO   = 3'd0,
        FC_NORM   = 3'd1,
        FC_INF    = 3'd2,
        FC_DENORM = 3'd3,
        FC_QNAN   = 3'd4,
        FC_SNAN   = 3'd5
    } fcls_e;
endpackage

// File: rtl/fpss_classify.sv
// Module fpss_classify: sorts one floating-point word into a class and
// produces its flushed form (a subnormal becomes a signed zero).
// Assumes a set top fraction bit marks a signaling NaN (R1); sign ignored.
module fpss_classify
    import fpss_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] val,
    output fcls_e                 cls,
    output logic [EXP_W+FRAC_W:0] flushed
);
    localparam int W = 1 + EXP_W + FRAC_W;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_ones, exp_zero, frac_zero;

    assign exp_f     = val[W-2 -: EXP_W];
    assign frac_f    = val[FRAC_W-1:0];
    assign exp_ones  = &exp_f;
    assign exp_zero  = ~|exp_f;
    assign frac_zero = ~|frac_f;

    // Purpose: pick the class from exponent and fraction fields (R1).
    always_comb begin
        if (exp_ones && !frac_zero)
            cls = frac_f[FRAC_W-1] ? FC_SNAN : FC_QNAN;
        else if (exp_ones)
            cls = FC_INF;
        else if (exp_zero && !frac_zero)
            cls = FC_DENORM;
        else if (exp_zero)
            cls = FC_ZERO;
        else
            cls = FC_NORM;
    end

    // Purpose: replace a subnormal by a zero carrying the same sign (R5, R6).
    always_comb begin
        if (cls == FC_DENORM)
            flushed = {val[W-1], {(W-1){1'b0}}};
        else
            flushed = val;
    end
endmodule

// File: rtl/fpss_decide.sv
// Module fpss_decide: chooses the final value, write enable and exception
// from the operand classes. Purely combinational.
// Assumes the core result arrives already classified and flushed.
module fpss_decide
    import fpss_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  fcls_e                 cls_a,
    input  fcls_e                 cls_b,
    input  logic                  two_ops,
    input  logic                  is_copy,
    input  logic                  inv_en,
    input  logic [EXP_W+FRAC_W:0] op_a,
    input  logic [EXP_W+FRAC_W:0] core_flushed,
    output logic [EXP_W+FRAC_W:0] nxt_result,
    output logic                  nxt_wr,
    output logic                  nxt_exc
);
    localparam int W = 1 + EXP_W + FRAC_W;
    localparam logic [W-1:0] QNAN_WORD =
        {1'b0, {EXP_W{1'b1}}, 1'b0, {(FRAC_W-1){1'b1}}};

    logic any_snan, any_qnan;

    // Purpose: combine operand classes; op_b only counts when active (R8).
    always_comb begin
        any_snan = (cls_a == FC_SNAN) || (two_ops && cls_b == FC_SNAN);
        any_qnan = (cls_a == FC_QNAN) || (two_ops && cls_b == FC_QNAN);
    end

    // Purpose: priority copy > trapped sNaN > NaN > core result (R2-R4, R6, R7).
    always_comb begin
        nxt_result = core_flushed;
        nxt_wr     = 1'b1;
        nxt_exc    = 1'b0;
        if (is_copy) begin
            nxt_result = op_a;
        end else if (any_snan && inv_en) begin
            nxt_result = QNAN_WORD;
            nxt_wr     = 1'b0;
            nxt_exc    = 1'b1;
        end else if (any_snan || any_qnan) begin
            nxt_result = QNAN_WORD;
        end
    end
endmodule

// File: rtl/fp_special_stage.sv
// Module fp_special_stage: top of the special-operand finalization stage.
// Classifies operands and core result, flushes subnormals, decides the
// write-back and registers the outputs one cycle after in_valid.
// Assumes core_res is a combinational function of core_opa/core_opb.
module fp_special_stage
    import fpss_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [EXP_W+FRAC_W:0] op_a,
    input  logic [EXP_W+FRAC_W:0] op_b,
    input  logic                  two_ops,
    input  logic                  is_copy,
    input  logic                  inv_en,
    output logic [EXP_W+FRAC_W:0] core_opa,
    output logic [EXP_W+FRAC_W:0] core_opb,
    input  logic [EXP_W+FRAC_W:0] core_res,
    output logic                  out_valid,
    output logic [EXP_W+FRAC_W:0] out_result,
    output logic                  out_wr_en,
    output logic                  out_inv_exc
);
    localparam int W     = 1 + EXP_W + FRAC_W;
    localparam int N_CLS = 3;

    logic [W-1:0] vals    [N_CLS];
    logic [W-1:0] flushed [N_CLS];
    fcls_e        cls     [N_CLS];

    logic [W-1:0] nxt_result;
    logic         nxt_wr, nxt_exc;
    logic         copy_q;

    assign vals[0] = op_a;
    assign vals[1] = op_b;
    assign vals[2] = core_res;

    // One classifier per word: operand a, operand b, core result.
    for (genvar gi = 0; gi < N_CLS; gi++) begin : g_cls
        fpss_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .val     (vals[gi]),
            .cls     (cls[gi]),
            .flushed (flushed[gi])
        );
    end

    // Purpose: feed the core flushed operands, or raw ones for a copy (R5, R7).
    always_comb begin
        core_opa = is_copy ? op_a : flushed[0];
        core_opb = is_copy ? op_b : flushed[1];
    end

    fpss_decide #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_dec (
        .cls_a        (cls[0]),
        .cls_b        (cls[1]),
        .two_ops      (two_ops),
        .is_copy      (is_copy),
        .inv_en       (inv_en),
        .op_a         (op_a),
        .core_flushed (flushed[2]),
        .nxt_result   (nxt_result),
        .nxt_wr       (nxt_wr),
        .nxt_exc      (nxt_exc)
    );

    // Purpose: output register stage with synchronous active-low reset (R9, R10).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_wr_en   <= 1'b0;
            out_inv_exc <= 1'b0;
            out_result  <= '0;
            copy_q      <= 1'b0;
        end else begin
            out_valid   <= in_valid;
            out_wr_en   <= in_valid & nxt_wr;
            out_inv_exc <= in_valid & nxt_exc;
            out_result  <= nxt_result;
            copy_q      <= is_copy;
        end
    end

    // R3: an exception never comes with a write.
    a_r3_exc_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        out_inv_exc |-> !out_wr_en);

    // R3: a valid result without a write must be an exception.
    a_r3_skip_only_on_exc: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_wr_en) |-> out_inv_exc);

    // R9: outputs follow in_valid one cycle later.
    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_wr_en && !out_inv_exc));

    // R5: the core never sees a subnormal on a non-copy operation.
    a_r5_core_no_denorm: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_copy) |->
            ((core_opa[W-2 -: EXP_W] != '0 || core_opa[FRAC_W-1:0] == '0) &&
             (core_opb[W-2 -: EXP_W] != '0 || core_opb[FRAC_W-1:0] == '0)));

    // R6: a written non-copy result is never subnormal.
    a_r6_result_no_denorm: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_wr_en && !copy_q) |->
            (out_result[W-2 -: EXP_W] != '0 || out_result[FRAC_W-1:0] == '0));
endmodule

// File: tb/tb_fp_special_stage.sv
// Bench: sweeps every class combination of both operands and the core
// result with all control flag settings; expectations computed here.
module tb_fp_special_stage;
    localparam logic [31:0] QNAN = 32'h7FBF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0, op_b = '0, core_res = '0;
    logic        two_ops = 1'b0, is_copy = 1'b0, inv_en = 1'b0;
    logic [31:0] core_opa, core_opb, out_result;
    logic        out_valid, out_wr_en, out_inv_exc;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    fp_special_stage dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .two_ops(two_ops), .is_copy(is_copy),
        .inv_en(inv_en), .core_opa(core_opa), .core_opb(core_opb),
        .core_res(core_res), .out_valid(out_valid), .out_result(out_result),
        .out_wr_en(out_wr_en), .out_inv_exc(out_inv_exc)
    );

    // Class codes used by the bench: 0 zero, 1 normal, 2 inf, 3 subnormal, 4 qNaN, 5 sNaN.
    function automatic logic [31:0] mk(int c, int k);
        logic s;
        logic [22:0] f;
        s = k[0];
        case (c)
            0: mk = {s, 8'h00, 23'h0};
            1: mk = {s, 8'((k * 37) % 254 + 1), 23'(k * 12345)};
            2: mk = {s, 8'hFF, 23'h0};
            3: begin f = 23'((k * 9973) % 8388607 + 1); mk = {s, 8'h00, f}; end
            4: mk = {s, 8'hFF, 1'b0, 22'((k * 777) % 4194303 + 1)};
            default: mk = {s, 8'hFF, 1'b1, 22'(k * 555)};
        endcase
    endfunction

    function automatic bit is_nan(logic [31:0] v);
        return (v[30:23] == 8'hFF) && (v[22:0] != 0);
    endfunction
    function automatic bit is_sn(logic [31:0] v);
        return is_nan(v) && v[22];
    endfunction
    function automatic bit is_qn(logic [31:0] v);
        return is_nan(v) && !v[22];
    endfunction
    function automatic logic [31:0] flz(logic [31:0] v);
        if (v[30:23] == 0 && v[22:0] != 0) return {v[31], 31'h0};
        return v;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int idx = 0;
        repeat (3) @(negedge clk);
        // R10: reset clears valid, write and exception.
        chk("R10 valid", 32'(out_valid), 0);
        chk("R10 wr", 32'(out_wr_en), 0);
        chk("R10 exc", 32'(out_inv_exc), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: idle cycle keeps outputs quiet.
        chk("R9 idle valid", 32'(out_valid), 0);

        for (int ca = 0; ca < 6; ca++)
        for (int cb = 0; cb < 6; cb++)
        for (int cr = 0; cr < 6; cr++)
        for (int fl = 0; fl < 8; fl++) begin
            logic [31:0] ea, eb, eres;
            logic ewr, eexc;
            bit sn, qn;
            idx++;
            op_a = mk(ca, idx);
            op_b = mk(cb, idx * 3 + 1);
            core_res = mk(cr, idx * 7 + 2);
            two_ops = fl[0];
            is_copy = fl[1];
            inv_en = fl[2];
            in_valid = 1'b1;
            sn = is_sn(op_a) || (two_ops && is_sn(op_b));
            qn = is_qn(op_a) || (two_ops && is_qn(op_b));
            ea = is_copy ? op_a : flz(op_a);
            eb = is_copy ? op_b : flz(op_b);
            ewr = 1'b1; eexc = 1'b0;
            if (is_copy) eres = op_a;
            else if (sn && inv_en) begin eres = QNAN; ewr = 1'b0; eexc = 1'b1; end
            else if (sn || qn) eres = QNAN;
            else eres = flz(core_res);
            #1;
            // R5 / R7: operands toward the core (flushed, or raw on copy).
            chk(is_copy ? "R7 core_opa" : "R5 core_opa", core_opa, ea);
            chk(is_copy ? "R7 core_opb" : "R5 core_opb", core_opb, eb);
            @(negedge clk);
            chk("R9 valid", 32'(out_valid), 1);
            if (ewr) begin
                // R2 R4 R6 R7 R8: value written (R1 classification underlies all).
                chk(is_copy ? "R7 result" : (sn ? "R2 result" :
                    (qn ? "R4 result" : (two_ops ? "R6 result" : "R8 R6 result"))),
                    out_result, eres);
            end
            chk(sn && inv_en && !is_copy ? "R3 wr" : "R1 R2 R4 R8 wr",
                32'(out_wr_en), 32'(ewr));
            chk(sn && inv_en && !is_copy ? "R3 exc" : "R1 R2 R4 R8 exc",
                32'(out_inv_exc), 32'(eexc));
        end

        in_valid = 1'b0;
        @(negedge clk);
        chk("R9 drop valid", 32'(out_valid), 0);
        chk("R9 drop wr", 32'(out_wr_en), 0);
        chk("R9 drop exc", 32'(out_inv_exc), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule